// File: doc/BRIEF.md
# I2C Slave Address-Matching Receiver

This block listens as a slave on a two-wire I2C bus. It oversamples SCL and SDA with the system clock, spots START and STOP conditions, and shifts in bytes MSB first on SCL rising edges. The first byte after a START is the address byte. Its upper seven bits are checked first for the all-zero general-call address and then against the address that software has programmed. Each outcome sets its own status flag and raises the interrupt line. Any other address clears both flags, and the rest of that transaction is ignored.

Once addressed, the slave takes bytes at the pace that software sets. Each accepted byte raises the interrupt. The next byte is taken only after software writes a dummy value to the data register. A byte that arrives before that write is neither captured nor acknowledged. The slave can pull SDA low during the ninth clock of each accepted byte, or it can be set never to drive the bus. A STOP ends the transaction and clears both address flags.

Top module: `i2c_srx_top`

## Requirements
- R1: After reset, all four registers read 0x00 and both `irq` and `sda_oe` are low.
- R2: Register offset 0 holds the own address in bits [7:1] and reads back as written, with bit 0 reading 0.
- R3: A START is SDA falling while SCL is high. Bits are taken on SCL rising edges, MSB first. Each accepted byte, the address byte included, can be read at register offset 2.
- R4: An address byte whose upper seven bits are all zero sets status bit 0 (general call), clears status bit 1 and raises `irq`. This holds even when the own address is also zero.
- R5: An address byte whose upper seven bits equal the own address (and are not zero) sets status bit 1 (own match), clears status bit 0 and raises `irq`.
- R6: Any other address clears status bits 0 and 1, raises no `irq` and is not acknowledged. Later bytes of that transaction are not acknowledged, captured or signalled.
- R7: `irq` (also status bit 2) stays high until software writes any value to offset 2. A data byte that completes while `irq` is high is not acknowledged, does not change the offset 2 value and leaves `irq` high. After the write, the next byte is accepted.
- R8: When control bit 1 is 1, the slave asserts `sda_oe` (pull SDA low) through the ninth SCL clock of every accepted byte. It raises `sda_oe` only while SCL is low. When control bit 1 is 0, `sda_oe` stays low, but flags, capture and `irq` still work.
- R9: A STOP (SDA rising while SCL is high) clears status bits 0 and 1. The pending `irq` and the offset 2 value are kept.
- R10: Control bit 0 enables the receiver. While it is 0, the bus is ignored: no flags, no capture, no `irq` and no `sda_oe`.
- R11: Status (offset 3) is read-only, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset: 0 own address, 1 control, 2 data, 3 status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| scl_in | input | 1 | SCL line as seen on the pin |
| sda_in | input | 1 | SDA line as seen on the pin |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| irq | output | 1 | Interrupt request, high while a byte awaits software |

## Verification
The bench sends every one of the 128 seven-bit addresses with a fixed own address. A design that compared the wrong bits, or let a general call fall through to the own-address test, would show wrong flags, a wrong acknowledge or a spurious interrupt. It also covers the edge settings of the own address: zero, where a general call must win, and all ones. A full sweep of 256 data bytes catches bit-order or bit-count slips. A byte sent while the interrupt is still pending must not be acknowledged or captured, and a design that ignored pacing would overwrite the buffer. Further runs cover the no-acknowledge mode, the disabled receiver, status writes, and STOP clearing the flags while keeping the pending byte.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;

    localparam int BYTE_W  = 8;
    localparam int SADDR_W = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);
    localparam int REG_AW  = 2;

    localparam logic [REG_AW-1:0] REG_OWN  = 2'd0;
    localparam logic [REG_AW-1:0] REG_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] REG_DATA = 2'd2;
    localparam logic [REG_AW-1:0] REG_STAT = 2'd3;

    typedef enum logic [1:0] {
        AC_NONE  = 2'd0,
        AC_GCALL = 2'd1,
        AC_OWN   = 2'd2
    } addr_class_e;

    typedef enum logic [1:0] {
        EN_IDLE = 2'd0,
        EN_BITS = 2'd1,
        EN_ACK  = 2'd2,
        EN_SKIP = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic ack_en;
        logic enable;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              is_addr;
        logic              take;
        addr_class_e       cls;
        logic [BYTE_W-1:0] data;
    } rx_event_t;

    // general call wins over an own address of zero
    function automatic addr_class_e classify(input logic [SADDR_W-1:0] rx,
                                             input logic [SADDR_W-1:0] own);
        if (rx == '0)
            return AC_GCALL;
        else if (rx == own)
            return AC_OWN;
        else
            return AC_NONE;
    endfunction

endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync
    import i2c_srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_srx_engine.sv
module i2c_srx_engine
    import i2c_srx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  bus_evt_t           ev,
    input  ctrl_t              ctrl,
    input  logic [SADDR_W-1:0] own_addr,
    input  logic               pending,
    output rx_event_t          evt,
    output logic               sda_oe
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    eng_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic              first;
    logic              keep;
    logic              ack_pend;

    logic [BYTE_W-1:0] nb;
    addr_class_e       cls_c;
    logic              take_c;

    always_comb begin
        nb     = {sh, ev.sda};
        cls_c  = classify(nb[BYTE_W-1:1], own_addr);
        take_c = first ? (cls_c != AC_NONE) : ~pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= EN_IDLE;
            cnt      <= '0;
            sh       <= '0;
            first    <= 1'b0;
            keep     <= 1'b0;
            ack_pend <= 1'b0;
            sda_oe   <= 1'b0;
            evt      <= '0;
        end else begin
            evt.valid <= 1'b0;
            if (!ctrl.enable) begin
                state  <= EN_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= EN_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state  <= EN_BITS;
                cnt    <= '0;
                first  <= 1'b1;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    EN_BITS: begin
                        if (ev.scl_rise && cnt < FULL) begin
                            sh  <= nb[BYTE_W-2:0];
                            cnt <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                evt.valid   <= 1'b1;
                                evt.is_addr <= first;
                                evt.take    <= take_c;
                                evt.cls     <= first ? cls_c : AC_NONE;
                                evt.data    <= nb;
                                ack_pend    <= take_c;
                                keep        <= first ? take_c : 1'b1;
                            end
                        end else if (ev.scl_fall && cnt == FULL) begin
                            state  <= EN_ACK;
                            sda_oe <= ack_pend & ctrl.ack_en;
                        end
                    end
                    EN_ACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            first  <= 1'b0;
                            state  <= keep ? EN_BITS : EN_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
    import i2c_srx_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  rx_event_t          evt,
    input  logic               stop,
    output ctrl_t              ctrl,
    output logic [SADDR_W-1:0] own_addr,
    output logic               pending,
    output logic               gc_flag,
    output logic               own_flag
);

    logic [BYTE_W-1:0] rx_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            own_addr <= '0;
            pending  <= 1'b0;
            gc_flag  <= 1'b0;
            own_flag <= 1'b0;
            rx_buf   <= '0;
        end else begin
            if (bus_wr) begin
                case (bus_addr)
                    REG_OWN:  own_addr <= bus_wdata[BYTE_W-1:1];
                    REG_CTRL: begin
                        ctrl.enable <= bus_wdata[0];
                        ctrl.ack_en <= bus_wdata[1];
                    end
                    REG_DATA: pending <= 1'b0;
                    default: ;
                endcase
            end
            if (stop) begin
                gc_flag  <= 1'b0;
                own_flag <= 1'b0;
            end
            if (evt.valid) begin
                if (evt.is_addr) begin
                    gc_flag  <= (evt.cls == AC_GCALL);
                    own_flag <= (evt.cls == AC_OWN);
                end
                if (evt.take) begin
                    rx_buf  <= evt.data;
                    pending <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (bus_addr)
            REG_OWN:  bus_rdata = {own_addr, 1'b0};
            REG_CTRL: bus_rdata = {{(BYTE_W-2){1'b0}}, ctrl.ack_en, ctrl.enable};
            REG_DATA: bus_rdata = rx_buf;
            default:  bus_rdata = {{(BYTE_W-3){1'b0}}, pending, own_flag, gc_flag};
        endcase
    end

endmodule

// File: rtl/i2c_srx_top.sv
module i2c_srx_top
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic              irq
);

    bus_evt_t           ev;
    ctrl_t              ctrl_q;
    rx_event_t          evt_q;
    logic [SADDR_W-1:0] own_q;
    logic               pending_q;
    logic               gc_q;
    logic               aas_q;

    i2c_srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2c_srx_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ctrl     (ctrl_q),
        .own_addr (own_q),
        .pending  (pending_q),
        .evt      (evt_q),
        .sda_oe   (sda_oe)
    );

    i2c_srx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt       (evt_q),
        .stop      (ev.stop),
        .ctrl      (ctrl_q),
        .own_addr  (own_q),
        .pending   (pending_q),
        .gc_flag   (gc_q),
        .own_flag  (aas_q)
    );

    assign irq = pending_q;

endmodule

// File: rtl/i2c_srx_checker.sv
module i2c_srx_checker (
    input logic       clk,
    input logic       rst,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       irq,
    input logic       enable,
    input logic       ack_en,
    input logic       gc,
    input logic       aas,
    input logic       stop,
    input logic       evt_take
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(gc && aas)); // R4

    AST_STOP_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!gc && !aas)); // R9

    AST_ACK_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ack_en)); // R8

    AST_ACK_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in); // R8

    AST_DUMMY_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd2 && !evt_take) |=> !irq); // R7

    AST_IRQ_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_take)); // R6

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!enable && $past(!enable)) |-> !sda_oe); // R10

endmodule

bind i2c_srx_top i2c_srx_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .irq      (irq),
    .enable   (ctrl_q.enable),
    .ack_en   (ctrl_q.ack_en),
    .gc       (gc_q),
    .aas      (aas_q),
    .stop     (ev.stop),
    .evt_take (evt_q.valid & evt_q.take)
);

// File: tb/test_i2c_srx_top.sv
module test_i2c_srx_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_srx_top i_i2c_srx_top (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .scl_in    (scl_m),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .irq       (irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1;
        scl_m = 1'b1;
        wait_clk(6);
        sda_m = 1'b0;
        wait_clk(10);
        scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        wait_clk(4);
        sda_m = 1'b0;
        wait_clk(6);
        scl_m = 1'b1;
        wait_clk(10);
        sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(4);
            sda_m = b[i];
            wait_clk(6);
            scl_m = 1'b1;
            wait_clk(10);
            scl_m = 1'b0;
        end
        wait_clk(4);
        sda_m = 1'b1;
        wait_clk(6);
        scl_m = 1'b1;
        wait_clk(5);
        acked = (sda_line == 1'b0);
        wait_clk(5);
        scl_m = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        bit ack;
        int own;
        int exp_gc;
        int exp_m;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(2);

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            cpu_read(r[1:0], rd);
            check("R1 register after reset", rd, 0);
        end
        check("R1 irq after reset", irq, 0);
        check("R1 sda_oe after reset", sda_oe, 0);

        // R2 own address register
        own = 'h5A;
        cpu_write(2'd0, 8'(own << 1) | 8'h01);
        cpu_read(2'd0, rd);
        check("R2 own address readback", rd, (own << 1) & 'hFE);
        cpu_write(2'd1, 8'h03);
        cpu_read(2'd1, rd);
        check("R10 control readback", rd, 3);

        // R4 R5 R6 sweep of every 7-bit address
        for (int a = 0; a < 128; a++) begin
            exp_gc = (a == 0) ? 1 : 0;
            exp_m  = (a == own) ? 1 : 0;
            i2c_start();
            i2c_byte(8'(a << 1), ack);
            check($sformatf("R5/R6 ack for address 0x%0h", a), ack, exp_gc | exp_m);
            cpu_read(2'd3, rd);
            check($sformatf("R4/R5/R6 status for address 0x%0h", a), rd,
                  ((exp_gc | exp_m) << 2) | (exp_m << 1) | exp_gc);
            check($sformatf("R6 irq for address 0x%0h", a), irq, exp_gc | exp_m);
            if ((exp_gc | exp_m) != 0) begin
                cpu_read(2'd2, rd);
                check("R3 address byte captured", rd, a << 1);
            end
            cpu_write(2'd2, 8'h00);
            i2c_stop();
            cpu_read(2'd3, rd);
            check("R9 flags cleared after STOP", rd, 0);
            check("R8 sda released after STOP", sda_oe, 0);
        end

        // R4 general call wins with own address zero
        cpu_write(2'd0, 8'h00);
        i2c_start();
        i2c_byte(8'h00, ack);
        check("R4 gcall ack, own zero", ack, 1);
        cpu_read(2'd3, rd);
        check("R4 gcall precedence status", rd, 'h05);
        cpu_write(2'd2, 8'h00);
        i2c_stop();

        // R5 own address all ones
        cpu_write(2'd0, 8'hFE);
        i2c_start();
        i2c_byte(8'hFE, ack);
        check("R5 own 0x7f ack", ack, 1);
        cpu_read(2'd3, rd);
        check("R5 own 0x7f status", rd, 'h06);
        cpu_write(2'd2, 8'h00);
        i2c_stop();
        i2c_start();
        i2c_byte(8'hFC, ack);
        check("R6 0x7e vs own 0x7f ack", ack, 0);
        cpu_read(2'd3, rd);
        check("R6 0x7e vs own 0x7f status", rd, 0);
        i2c_stop();

        // R7 software pacing, R3 data bytes MSB first
        cpu_write(2'd0, 8'hB4);
        i2c_start();
        i2c_byte(8'hB4, ack);
        check("R5 match before data", ack, 1);
        check("R7 irq after match", irq, 1);
        i2c_byte(8'h3C, ack);
        check("R7 unreleased byte not acked", ack, 0);
        cpu_read(2'd2, rd);
        check("R7 unreleased byte not captured", rd, 'hB4);
        check("R7 irq held while unreleased", irq, 1);
        for (int d = 0; d < 256; d++) begin
            cpu_write(2'd2, 8'h00);
            check("R7 irq cleared by dummy write", irq, 0);
            i2c_byte(8'(d), ack);
            check($sformatf("R8 ack data 0x%0h", d), ack, 1);
            cpu_read(2'd2, rd);
            check($sformatf("R3 data 0x%0h captured", d), rd, d);
            check("R7 irq after data", irq, 1);
        end
        i2c_stop();
        cpu_read(2'd3, rd);
        check("R9 STOP keeps pending, clears flags", rd, 'h04);
        check("R9 irq kept across STOP", irq, 1);
        cpu_read(2'd2, rd);
        check("R9 buffer kept across STOP", rd, 'hFF);
        cpu_write(2'd2, 8'h00);

        // R6 rest of an unmatched transaction ignored
        i2c_start();
        i2c_byte(8'h22, ack);
        check("R6 mismatch not acked", ack, 0);
        cpu_write(2'd2, 8'h00);
        i2c_byte(8'h55, ack);
        check("R6 later byte not acked", ack, 0);
        check("R6 later byte no irq", irq, 0);
        cpu_read(2'd2, rd);
        check("R6 later byte not captured", rd, 'hFF);
        i2c_stop();

        // R8 no-acknowledge mode
        cpu_write(2'd1, 8'h01);
        i2c_start();
        i2c_byte(8'hB4, ack);
        check("R8 no ack in no-ack mode", ack, 0);
        cpu_read(2'd3, rd);
        check("R8 flags still set in no-ack mode", rd, 'h06);
        cpu_write(2'd2, 8'h00);
        i2c_byte(8'h99, ack);
        check("R8 data not acked in no-ack mode", ack, 0);
        cpu_read(2'd2, rd);
        check("R8 data captured in no-ack mode", rd, 'h99);
        check("R8 irq in no-ack mode", irq, 1);
        i2c_stop();
        cpu_write(2'd2, 8'h00);

        // R11 status writes ignored
        cpu_write(2'd3, 8'hFF);
        cpu_read(2'd3, rd);
        check("R11 status write ignored", rd, 0);
        cpu_read(2'd2, rd);
        check("R11 data unchanged by status write", rd, 'h99);

        // R10 disabled receiver
        cpu_write(2'd1, 8'h02);
        i2c_start();
        i2c_byte(8'hB4, ack);
        check("R10 disabled no ack", ack, 0);
        cpu_read(2'd3, rd);
        check("R10 disabled no flags", rd, 0);
        check("R10 disabled no irq", irq, 0);
        i2c_stop();
        cpu_write(2'd1, 8'h03);
        i2c_start();
        i2c_byte(8'hB4, ack);
        check("R10 re-enabled ack", ack, 1);
        i2c_stop();
        cpu_write(2'd2, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule